// File: doc/BRIEF.md
# Multi-CPU GPIO Interrupt Aggregator

This block is a bank of up to 32 general-purpose pins. Each pin has a drive value, a direction and an input inversion bit. Raw pin inputs pass through a two-flop synchronizer. Each synchronized value is then XORed with its inversion bit to give the pin's effective input.

Rising transitions of the effective input set sticky bits in an edge-cause register, and every CPU has its own copy of that register. The effective level is also offered directly as a level source. Each CPU has its own edge mask and level mask and drives its own registered interrupt line. Falling-edge or active-low detection is obtained by setting the inversion bit. Software reaches all registers through a simple word-wide read/write port, and read data returns one cycle after the request.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register (address 0x04) reads all ones, and the drive register (0x00) and inversion register (0x08) read zero. Every per-CPU cause and mask reads zero, `cpu_irq` is 0 and `pin_oe` is 0.
- R2: The pin register (0x0C) returns the synchronized raw input XORed with the inversion bit for every pin whose direction bit is 1 (input).
- R3: For a pin whose direction bit is 0 (output), the pin register returns the drive register bit. `pin_out` equals the drive register and `pin_oe` is the inverse of the direction register.
- R4: A 0-to-1 change of a pin's effective input sets that pin's bit in the cause register of every CPU. With the inversion bit set, this means a falling edge of the raw pin sets the bit.
- R5: A write to a cause register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R6: When an edge arrives in the same cycle as a write that clears the same cause bit, the bit ends set.
- R7: A pin whose direction bit is 0 sets no cause bit and contributes no level interrupt.
- R8: `cpu_irq[n]` is the OR over all pins of (cause AND edge mask) and (effective input AND direction AND level mask) for CPU n, independently for each CPU.
- R9: The per-CPU window decodes CPU n's cause register at 0x40+4n, its edge mask at 0x50+4n and its level mask at 0x60+4n, for n from 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NPINS | Raw pin inputs (asynchronous) |
| pin_out | output | NPINS | Pad drive values |
| pin_oe | output | NPINS | Pad output enables |
| cpu_irq | output | NCPU | Registered interrupt line per CPU |

## Verification
The hardest case to reach is the collision between a detected edge and a software clear of the same cause bit. The edge is only visible internally for one cycle, two clock edges after the raw pin moves. The bench sets a pin between clock edges, counts exactly two falling edges, and then issues the clearing write so that the write and the internal edge meet at the same clock edge. Random sequences of pin, inversion, direction and mask changes are mixed with cause clears, and all CPUs' interrupt lines are compared with a bench model after each change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W   = 7;
  localparam int BUS_W    = 32;
  // main window
  localparam logic [5:0] OFS_DRIVE = 6'h00;
  localparam logic [5:0] OFS_DIR   = 6'h04;
  localparam logic [5:0] OFS_INV   = 6'h08;
  localparam logic [5:0] OFS_PIN   = 6'h0C;
  // per-CPU window (address bit 6 set); bits [5:4] pick the register kind
  localparam logic [1:0] KIND_CAUSE = 2'd0;
  localparam logic [1:0] KIND_EMASK = 2'd1;
  localparam logic [1:0] KIND_LMASK = 2'd2;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] raw_i,
  input  logic [NPINS-1:0] inv_i,
  input  logic [NPINS-1:0] dir_i,
  output logic [NPINS-1:0] eff_o,
  output logic [NPINS-1:0] edge_o,
  output logic [NPINS-1:0] level_o
);
  logic [NPINS-1:0] sync1_q, sync2_q, eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
      eff_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      eff_q   <= eff_o;
    end
  end

  assign eff_o   = sync2_q ^ inv_i;
  assign edge_o  = eff_o & ~eff_q & dir_i;
  assign level_o = eff_o & dir_i;
endmodule

// File: rtl/gpio_cpu_irq.sv
module gpio_cpu_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cause,
  input  logic             wr_emask,
  input  logic             wr_lmask,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] edge_i,
  input  logic [NPINS-1:0] level_i,
  input  logic [NPINS-1:0] src_en,
  output logic [NPINS-1:0] cause_o,
  output logic [NPINS-1:0] emask_o,
  output logic [NPINS-1:0] lmask_o,
  output logic             irq_o
);
  logic [NPINS-1:0] cause_keep;

  always_comb begin
    cause_keep = wr_cause ? (cause_o & wdata) : cause_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_o <= '0;
      emask_o <= '0;
      lmask_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      cause_o <= cause_keep | edge_i;
      if (wr_emask) emask_o <= wdata;
      if (wr_lmask) lmask_o <= wdata;
      irq_o   <= |((cause_o & emask_o) | (level_i & lmask_o));
    end
  end

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (|edge_i) |=> ((cause_o & $past(edge_i)) == $past(edge_i))); // R6
  AST_CAUSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(edge_i)) == '0)); // R4
  AST_OUTPUT_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cause_o & ~$past(cause_o) & ~$past(src_en)) == '0)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((emask_o == '0) && (lmask_o == '0)) |=> !irq_o); // R8
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NCPU  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NCPU-1:0]   cpu_irq
);
  localparam int CPU_SEL_W = 2;

  logic [NPINS-1:0] drive_q, dir_q, inv_q;
  logic [NPINS-1:0] eff, edge_det, level_src;
  logic [NPINS-1:0] cause_v [NCPU];
  logic [NPINS-1:0] emask_v [NCPU];
  logic [NPINS-1:0] lmask_v [NCPU];
  logic [NPINS-1:0] wd;
  logic             aligned, main_win, cpu_win;
  logic [1:0]       kind;
  logic [CPU_SEL_W-1:0] cpu_sel;
  logic [31:0]      rd_next;

  assign wd       = bus_wdata[NPINS-1:0];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign main_win = aligned && !bus_addr[6];
  assign cpu_win  = aligned && bus_addr[6];
  assign kind     = bus_addr[5:4];
  assign cpu_sel  = bus_addr[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= '0;
      dir_q   <= '1;
      inv_q   <= '0;
    end else if (bus_wr && main_win) begin
      if (bus_addr[5:0] == OFS_DRIVE) drive_q <= wd;
      if (bus_addr[5:0] == OFS_DIR)   dir_q   <= wd;
      if (bus_addr[5:0] == OFS_INV)   inv_q   <= wd;
    end
  end

  gpio_in_cond #(.NPINS(NPINS)) u_cond (
    .clk(clk), .rst(rst), .raw_i(pin_in), .inv_i(inv_q), .dir_i(dir_q),
    .eff_o(eff), .edge_o(edge_det), .level_o(level_src)
  );

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic hit;
    assign hit = bus_wr && cpu_win && (cpu_sel == CPU_SEL_W'(g));
    gpio_cpu_irq #(.NPINS(NPINS)) u_cpu (
      .clk(clk), .rst(rst),
      .wr_cause(hit && kind == KIND_CAUSE),
      .wr_emask(hit && kind == KIND_EMASK),
      .wr_lmask(hit && kind == KIND_LMASK),
      .wdata(wd), .edge_i(edge_det), .level_i(level_src), .src_en(dir_q),
      .cause_o(cause_v[g]), .emask_o(emask_v[g]), .lmask_o(lmask_v[g]),
      .irq_o(cpu_irq[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (main_win) begin
      case (bus_addr[5:0])
        OFS_DRIVE: rd_next[NPINS-1:0] = drive_q;
        OFS_DIR:   rd_next[NPINS-1:0] = dir_q;
        OFS_INV:   rd_next[NPINS-1:0] = inv_q;
        OFS_PIN:   rd_next[NPINS-1:0] = (eff & dir_q) | (drive_q & ~dir_q);
        default:   rd_next = '0;
      endcase
    end else if (cpu_win) begin
      for (int c = 0; c < NCPU; c++) begin
        if (cpu_sel == CPU_SEL_W'(c)) begin
          case (kind)
            KIND_CAUSE: rd_next[NPINS-1:0] = cause_v[c];
            KIND_EMASK: rd_next[NPINS-1:0] = emask_v[c];
            KIND_LMASK: rd_next[NPINS-1:0] = lmask_v[c];
            default:    rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign pin_out = drive_q;
  assign pin_oe  = ~dir_q;

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (cpu_irq == '0)); // R1
endmodule

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int NC = 4;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NC-1:0] cpu_irq;

  int n_run = 0, n_fail = 0;

  logic [31:0] m_drive, m_dir, m_inv, m_raw, m_prev;
  logic [31:0] m_cause [NC];
  logic [31:0] m_em [NC];
  logic [31:0] m_lm [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NPINS(NP), .NCPU(NC)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [6:0] caddr(input int kind, input int n);
    return 7'(8'h40 + kind * 16 + 4 * n);
  endfunction

  function automatic logic [31:0] eff_now();
    return m_raw ^ m_inv;
  endfunction

  function automatic logic [31:0] pin_val();
    return (eff_now() & m_dir) | (m_drive & ~m_dir);
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r;
    for (int n = 0; n < NC; n++)
      r[n] = |((m_cause[n] & m_em[n]) | (eff_now() & m_dir & m_lm[n]));
    return r;
  endfunction

  // model one settled change: rising effective input on input pins sets causes
  task automatic settle();
    logic [31:0] e, rise;
    e = eff_now();
    rise = e & ~m_prev & m_dir;
    for (int n = 0; n < NC; n++) m_cause[n] |= rise;
    m_prev = e;
    repeat (5) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    m_drive = '0; m_dir = '1; m_inv = '0; m_raw = '0; m_prev = '0;
    for (int n = 0; n < NC; n++) begin m_cause[n] = '0; m_em[n] = '0; m_lm[n] = '0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    read_chk("R1 dir", 7'h04, 32'hFFFF_FFFF);
    read_chk("R1 drive", 7'h00, 0);
    read_chk("R1 inv", 7'h08, 0);
    chk("R1 irq", 32'(cpu_irq), 0);
    chk("R1 oe", pin_oe, 0);
    for (int n = 0; n < NC; n++)
      for (int k = 0; k < 3; k++) read_chk("R1 percpu", caddr(k, n), 0);

    // R9 distinct per-CPU register decode
    for (int n = 0; n < NC; n++) begin
      m_em[n] = 32'h1000_0000 << n; wr(caddr(1, n), m_em[n]);
      m_lm[n] = 32'h0000_0100 << n; wr(caddr(2, n), m_lm[n]);
    end
    for (int n = 0; n < NC; n++) begin
      read_chk("R9 emask", caddr(1, n), 32'h1000_0000 << n);
      read_chk("R9 lmask", caddr(2, n), 32'h0000_0100 << n);
    end

    // R2 inversion on input pins
    m_raw = 32'h0000_00F0; pin_in = m_raw; settle();
    m_inv = 32'h0000_0FF0; wr(7'h08, m_inv); settle();
    read_chk("R2 pin", 7'h0C, 32'h0000_0F00);

    // R4 falling raw edge with inversion sets cause on every CPU
    m_raw = 32'h0000_0000; pin_in = m_raw; settle();
    for (int n = 0; n < NC; n++) read_chk("R4 cause", caddr(0, n), m_cause[n]);
    chk("R4 cause_bits", m_cause[0] & 32'h0000_00F0, 32'h0000_00F0);

    // R5 write-zero clears, write-one keeps
    wr(caddr(0, 1), 32'hFFFF_FF0F); m_cause[1] &= 32'hFFFF_FF0F; settle();
    read_chk("R5 clr", caddr(0, 1), m_cause[1]);
    read_chk("R5 keep", caddr(0, 0), m_cause[0]);

    // R3 output pins
    m_drive = 32'hA5A5_0000; wr(7'h00, m_drive);
    m_dir = 32'h0000_FFFF; wr(7'h04, m_dir); settle();
    chk("R3 oe", pin_oe, 32'hFFFF_0000);
    chk("R3 out", pin_out, 32'hA5A5_0000);
    read_chk("R3 pin", 7'h0C, pin_val());

    // R7 output pin toggling sets no cause and gives no level irq
    for (int n = 0; n < NC; n++) begin wr(caddr(0, n), 0); m_cause[n] = '0; end
    m_lm[2] = 32'hFFFF_0000; wr(caddr(2, 2), m_lm[2]);
    m_em[2] = 32'hFFFF_0000; wr(caddr(1, 2), m_em[2]);
    m_raw = 32'hFFFF_0000; pin_in = m_raw; settle();
    read_chk("R7 cause", caddr(0, 2), 0);
    chk("R7 irq", 32'(cpu_irq[2]), 0);

    // R6 edge coinciding with clear
    m_dir = '1; wr(7'h04, m_dir); m_inv = '0; wr(7'h08, 0);
    m_raw = 0; pin_in = 0; settle();
    for (int n = 0; n < NC; n++) begin wr(caddr(0, n), 0); m_cause[n] = '0; end
    pin_in = 32'h1; m_raw = 32'h1;
    @(negedge clk); @(negedge clk);
    wr(caddr(0, 0), 32'h0);
    m_prev = eff_now();
    for (int n = 0; n < NC; n++) m_cause[n] = 32'h1;
    repeat (4) @(negedge clk);
    read_chk("R6 race", caddr(0, 0), 32'h1);

    // R8 random mix
    for (int it = 0; it < 400; it++) begin
      int op, n;
      logic [31:0] v;
      op = $urandom_range(0, 5); n = $urandom_range(0, NC-1); v = $urandom;
      case (op)
        0: begin m_raw = v; pin_in = v; end
        1: begin m_inv = v; wr(7'h08, v); end
        2: begin m_dir = v | 32'hFFFF_0000; wr(7'h04, m_dir); end
        3: begin m_em[n] = v; wr(caddr(1, n), v); end
        4: begin m_lm[n] = v; wr(caddr(2, n), v); end
        default: begin
          v = v | ($urandom & $urandom);
          m_cause[n] &= v; wr(caddr(0, n), v);
        end
      endcase
      settle();
      chk("R8 irq", 32'(cpu_irq), 32'(exp_irq()));
      if (it % 8 == 0) begin
        read_chk("R2 pin_rand", 7'h0C, pin_val());
        read_chk("R4 cause_rand", caddr(0, n), m_cause[n]);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule